// File: doc/BRIEF.md
# Integer Execute-Stage Operand Forwarding Unit

This block chooses where each of the two source operands of the integer execute stage comes from in a seven-stage in-order pipeline (two fetch stages, decode, execute, two memory stages, write-back). The source operands can come from the value read out of the register file during decode. They can also come from a result that a later instruction has produced but not yet written back. Results can wait in three inter-stage latches: execute/mem1, mem1/mem2 and mem2/write-back. The block compares each source register number of the instruction in execute with the destination held in each latch. It then produces a 2-bit select per operand and the selected 32-bit operand value.

A load's data exists only after the second memory stage. For that reason, a load still in the execute/mem1 or mem1/mem2 latch is never used as a source. The stall that such a case needs is produced elsewhere. In the write-back latch, the forwarded value is the load data or the ALU result, chosen by that latch's memory-to-register bit. Register zero always reads as zero and is never forwarded. The block is purely combinational. The clock and reset inputs serve only to sample its built-in checks.

Top module: `fwd_ex_int`

## Requirements
- R1: Each operand select is encoded as 2'b00 = register file value, 2'b01 = execute/mem1 ALU result, 2'b10 = mem1/mem2 ALU result, 2'b11 = write-back latch value. The operand output always equals the source that its select names.
- R2: A latch is a forwarding candidate for an operand only when its write-enable is 1 and its destination equals that operand's source register number.
- R3: When an operand's source register is 0, its select is 2'b00 and the register file value passes through, whatever the latches hold.
- R4: When several latches are candidates, the youngest wins: execute/mem1 over mem1/mem2 over mem2/write-back.
- R5: A latch in execute/mem1 or mem1/mem2 that holds a load (load flag = 1) is never selected. Selection falls to the next older candidate, or to the register file.
- R6: The write-back path value is the load data when the memory-to-register bit is 1, and the ALU result when it is 0.
- R7: With no candidate, the select is 2'b00 and the operand equals the register file value.
- R8: The two operands are resolved independently; each uses only its own source number and register file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the built-in checks |
| rst | input | 1 | Synchronous active-high reset, disables checks |
| ex_rs1 | input | 5 | First source register number in execute |
| ex_rs2 | input | 5 | Second source register number in execute |
| rf_rd1 | input | 32 | Register file value for first source |
| rf_rd2 | input | 32 | Register file value for second source |
| xm_wr_en | input | 1 | execute/mem1 register write enable |
| xm_dest | input | 5 | execute/mem1 destination register |
| xm_is_load | input | 1 | execute/mem1 holds a load |
| xm_alu | input | 32 | execute/mem1 ALU result |
| mm_wr_en | input | 1 | mem1/mem2 register write enable |
| mm_dest | input | 5 | mem1/mem2 destination register |
| mm_is_load | input | 1 | mem1/mem2 holds a load |
| mm_alu | input | 32 | mem1/mem2 ALU result |
| mr_wr_en | input | 1 | write-back latch register write enable |
| mr_dest | input | 5 | write-back latch destination register |
| mr_mem_to_reg | input | 1 | write-back latch takes load data |
| mr_alu | input | 32 | write-back latch ALU result |
| mr_load | input | 32 | write-back latch load data |
| sel_a | output | 2 | First operand source select |
| sel_b | output | 2 | Second operand source select |
| opnd_a | output | 32 | First operand value |
| opnd_b | output | 32 | Second operand value |

## Verification
The bench targets a source of register zero while every latch claims to write register zero. A design that forgot the zero guard would forward a non-zero result there. It also sets up the same destination in all three latches to test the priority; a reversed priority hands execute a stale, older result. Loads placed in the two young latches check that the selection falls through to an older latch or to the register file rather than taking an ALU value that is not yet valid. The write-back path is run with both settings of its memory-to-register bit, which exposes a mux that picks the wrong one.

// File: rtl/fwd_ex_pkg.sv
package fwd_ex_pkg;
    parameter int unsigned XLEN     = 32;
    parameter int unsigned NREG     = 32;
    parameter int unsigned NUM_PROD = 3;
    parameter int unsigned NUM_OPND = 2;
    localparam int unsigned REG_W   = $clog2(NREG);

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [REG_W-1:0] reg_idx_t;

    // Select code value i+1 names producer latch i (0 = youngest).
    typedef enum logic [1:0] {
        SRC_RF = 2'b00,
        SRC_XM = 2'b01,
        SRC_MM = 2'b10,
        SRC_MR = 2'b11
    } fwd_src_e;

    typedef struct packed {
        logic     wr_en;
        reg_idx_t dest;
        logic     not_ready;   // result not yet valid in this latch
    } producer_t;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_ex_pkg::*;
(
    input  reg_idx_t            src,
    input  producer_t           prod [NUM_PROD],
    output logic [NUM_PROD-1:0] hit
);
    for (genvar i = 0; i < NUM_PROD; i++) begin : g_cmp
        assign hit[i] = prod[i].wr_en && !prod[i].not_ready
                        && (prod[i].dest != '0) && (prod[i].dest == src);
    end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
    import fwd_ex_pkg::*;
(
    input  logic [NUM_PROD-1:0] hit,
    output fwd_src_e            sel
);
    always_comb begin
        sel = SRC_RF;
        // walk oldest to youngest so the youngest hit overrides
        for (int i = NUM_PROD - 1; i >= 0; i--) begin
            if (hit[i]) sel = fwd_src_e'(2'(i + 1));
        end
    end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_ex_pkg::*;
(
    input  fwd_src_e sel,
    input  word_t    rf_val,
    input  word_t    fwd_val [NUM_PROD],
    output word_t    opnd
);
    always_comb begin
        unique case (sel)
            SRC_XM:  opnd = fwd_val[0];
            SRC_MM:  opnd = fwd_val[1];
            SRC_MR:  opnd = fwd_val[2];
            default: opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_ex_int.sv
module fwd_ex_int
    import fwd_ex_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [XLEN-1:0] rf_rd1,
    input  logic [XLEN-1:0] rf_rd2,
    input  logic            xm_wr_en,
    input  logic [REG_W-1:0] xm_dest,
    input  logic            xm_is_load,
    input  logic [XLEN-1:0] xm_alu,
    input  logic            mm_wr_en,
    input  logic [REG_W-1:0] mm_dest,
    input  logic            mm_is_load,
    input  logic [XLEN-1:0] mm_alu,
    input  logic            mr_wr_en,
    input  logic [REG_W-1:0] mr_dest,
    input  logic            mr_mem_to_reg,
    input  logic [XLEN-1:0] mr_alu,
    input  logic [XLEN-1:0] mr_load,
    output logic [1:0]      sel_a,
    output logic [1:0]      sel_b,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b
);
    producer_t prod    [NUM_PROD];
    word_t     fwd_val [NUM_PROD];
    word_t     mr_value;
    reg_idx_t  src     [NUM_OPND];
    word_t     rf_val  [NUM_OPND];
    fwd_src_e  sel     [NUM_OPND];
    word_t     opnd    [NUM_OPND];

    // write-back latch: load data or ALU result (R6)
    assign mr_value = mr_mem_to_reg ? mr_load : mr_alu;

    // loads in the two young latches are not ready (R5)
    assign prod[0] = '{wr_en: xm_wr_en, dest: xm_dest, not_ready: xm_is_load};
    assign prod[1] = '{wr_en: mm_wr_en, dest: mm_dest, not_ready: mm_is_load};
    assign prod[2] = '{wr_en: mr_wr_en, dest: mr_dest, not_ready: 1'b0};

    assign fwd_val[0] = xm_alu;
    assign fwd_val[1] = mm_alu;
    assign fwd_val[2] = mr_value;

    assign src[0]    = ex_rs1;
    assign src[1]    = ex_rs2;
    assign rf_val[0] = rf_rd1;
    assign rf_val[1] = rf_rd2;

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
        logic [NUM_PROD-1:0] hit;
        fwd_match u_match (.src(src[k]), .prod(prod), .hit(hit));
        fwd_prio  u_prio  (.hit(hit), .sel(sel[k]));
        fwd_opmux u_mux   (.sel(sel[k]), .rf_val(rf_val[k]),
                           .fwd_val(fwd_val), .opnd(opnd[k]));
    end

    assign sel_a  = sel[0];
    assign sel_b  = sel[1];
    assign opnd_a = opnd[0];
    assign opnd_b = opnd[1];

    // ---------------- checks ----------------
    p_zero_src_rf_r3: assert property (@(posedge clk) disable iff (rst)
        (ex_rs1 == '0) |-> (sel_a == 2'b00 && opnd_a == rf_rd1));

    p_young_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (xm_wr_en && !xm_is_load && xm_dest != '0 && xm_dest == ex_rs2)
        |-> (sel_b == 2'b01 && opnd_b == xm_alu));

    p_xm_not_load_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_a == 2'b01) |-> !xm_is_load);

    p_mm_not_load_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_b == 2'b10) |-> (!mm_is_load && opnd_b == mm_alu));

    p_mr_data_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_a == 2'b11) |-> (opnd_a == (mr_mem_to_reg ? mr_load : mr_alu)));

    p_mr_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_b == 2'b11) |-> (mr_wr_en && mr_dest == ex_rs2));

    p_rf_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (sel_b == 2'b00) |-> (opnd_b == rf_rd2));
endmodule

// File: tb/fwd_ex_int_bench.sv
module fwd_ex_int_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  ex_rs1, ex_rs2, xm_dest, mm_dest, mr_dest;
    logic [31:0] rf_rd1, rf_rd2, xm_alu, mm_alu, mr_alu, mr_load;
    logic        xm_wr_en, xm_is_load, mm_wr_en, mm_is_load, mr_wr_en, mr_mem_to_reg;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    fwd_ex_int u_fwd_ex_int (.*);

    function automatic logic [1:0] ref_sel(input logic [4:0] rs);
        if (rs != 0 && xm_wr_en && !xm_is_load && xm_dest == rs) return 2'b01;
        if (rs != 0 && mm_wr_en && !mm_is_load && mm_dest == rs) return 2'b10;
        if (rs != 0 && mr_wr_en && mr_dest == rs)                return 2'b11;
        return 2'b00;
    endfunction

    function automatic logic [31:0] ref_val(input logic [1:0] s, input logic [31:0] rf);
        case (s)
            2'b01:   return xm_alu;
            2'b10:   return mm_alu;
            2'b11:   return mr_mem_to_reg ? mr_load : mr_alu;
            default: return rf;
        endcase
    endfunction

    task automatic check(input string req);
        logic [1:0]  ea, eb;
        logic [31:0] va, vb;
        @(posedge clk); #1;
        ea = ref_sel(ex_rs1); eb = ref_sel(ex_rs2);
        va = ref_val(ea, rf_rd1); vb = ref_val(eb, rf_rd2);
        checks++;
        if (sel_a !== ea || opnd_a !== va || sel_b !== eb || opnd_b !== vb) begin
            errors++;
            $display("FAIL %s: sel_a=%0d opnd_a=%h sel_b=%0d opnd_b=%h expected %0d %h %0d %h",
                     req, sel_a, opnd_a, sel_b, opnd_b, ea, va, eb, vb);
        end
    endtask

    task automatic expect_sel(input string req, input logic [1:0] a, input logic [1:0] b);
        @(posedge clk); #1;
        checks++;
        if (sel_a !== a || sel_b !== b) begin
            errors++;
            $display("FAIL %s: sel_a=%0d sel_b=%0d expected %0d %0d", req, sel_a, sel_b, a, b);
        end
    endtask

    task automatic clear();
        {ex_rs1, ex_rs2, xm_dest, mm_dest, mr_dest} = '0;
        {xm_wr_en, xm_is_load, mm_wr_en, mm_is_load, mr_wr_en, mr_mem_to_reg} = '0;
        rf_rd1 = 32'h1111_0001; rf_rd2 = 32'h2222_0002;
        xm_alu = 32'hAAAA_0001; mm_alu = 32'hBBBB_0002;
        mr_alu = 32'hCCCC_0003; mr_load = 32'hDDDD_0004;
    endtask

    initial begin
        clear();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R7: reset state, nothing writing
        expect_sel("R7 idle", 2'b00, 2'b00);
        check("R7 idle data");
        // R3: all latches target r0, sources are r0
        @(negedge clk);
        xm_wr_en = 1; mm_wr_en = 1; mr_wr_en = 1;
        expect_sel("R3 zero src", 2'b00, 2'b00);
        // R4: all three latches hold r5
        @(negedge clk);
        xm_dest = 5; mm_dest = 5; mr_dest = 5; ex_rs1 = 5; ex_rs2 = 5;
        expect_sel("R4 all match", 2'b01, 2'b01);
        // R4: drop youngest
        @(negedge clk); xm_dest = 6;
        expect_sel("R4 mm over mr", 2'b10, 2'b10);
        // R5: load in mm falls to mr
        @(negedge clk); mm_is_load = 1;
        expect_sel("R5 mm load", 2'b11, 2'b11);
        // R5: load in xm falls to mm
        @(negedge clk); mm_is_load = 0; xm_dest = 5; xm_is_load = 1;
        expect_sel("R5 xm load", 2'b10, 2'b10);
        // R6: write-back path both ways
        @(negedge clk); clear(); mr_wr_en = 1; mr_dest = 9; ex_rs1 = 9; mr_mem_to_reg = 1;
        check("R6 load data");
        expect_sel("R1 wb code", 2'b11, 2'b00);
        @(negedge clk); mr_mem_to_reg = 0;
        check("R6 alu data");
        // R2: write enable low blocks match
        @(negedge clk); mr_wr_en = 0;
        expect_sel("R2 wr_en low", 2'b00, 2'b00);
        // R8: independent operands
        @(negedge clk); clear(); xm_wr_en = 1; xm_dest = 3; mm_wr_en = 1; mm_dest = 4;
        ex_rs1 = 3; ex_rs2 = 4;
        expect_sel("R8 split", 2'b01, 2'b10);
        check("R8 split data");
        // R1: constrained random, small register range to force matches
        void'($urandom(32'd1234));
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            ex_rs1 = 5'($urandom_range(0, 3)); ex_rs2 = 5'($urandom_range(0, 3));
            xm_dest = 5'($urandom_range(0, 3)); mm_dest = 5'($urandom_range(0, 3));
            mr_dest = 5'($urandom_range(0, 3));
            {xm_wr_en, xm_is_load, mm_wr_en, mm_is_load, mr_wr_en, mr_mem_to_reg} = 6'($urandom);
            rf_rd1 = $urandom; rf_rd2 = $urandom; xm_alu = $urandom; mm_alu = $urandom;
            mr_alu = $urandom; mr_load = $urandom;
            check("R1 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: bench hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule